// File: doc/BRIEF.md
# Seconds Stopwatch with Victory Pattern

This block is a small stopwatch controller that counts whole seconds from 00 up to a fixed ceiling of 20 and then stays there. A prescaler derives a one-second tick from the free-running system clock. A single push-button starts and pauses the count. A second push-button sets the count back to 00. The count leaves the block as two BCD digits, tens and units, so a separate display driver can show them without any division. Scanning the display digits is left to that driver.

Each button passes through a two-stage synchronizer. The start/pause button then goes through a rising-edge detector, so one press toggles the run state once, however long the button is held. While the count sits at its ceiling, a 16-LED vector shows a single lit LED. That LED walks upward from bit 0 to bit 15 and wraps back to bit 0, stepping on a faster tick than the seconds tick. At any other count the LEDs are dark.

Top module: `sw_stopwatch`

## Requirements
- R1: Reset makes the count 00, turns all LEDs off and leaves the stopwatch paused. With no button pressed after reset, the count stays at 00.
- R2: While running, the count advances by one every SEC_CYCLES clock cycles. The prescaler phase is kept across a pause.
- R3: The count stops at MAX_COUNT (20) and holds there while running. It never shows a higher value.
- R4: Each rising edge of the synchronized start/pause button toggles between running and paused. Holding the button down toggles only once.
- R5: While paused, the count holds its value. A later press resumes counting from that value.
- R6: While the synchronized clear button is high, the count is 00 and the seconds prescaler restarts. The run state is not changed.
- R7: At every count other than the ceiling, all LEDs are 0.
- R8: At the ceiling exactly one LED is lit. It is bit 0 in the first cycle at the ceiling and moves to the next higher bit every SEC_CYCLES/STEPS_PER_SEC cycles. After bit 15 it returns to bit 0.
- R9: The outputs are BCD. units_bcd is 0 to 9, and tens_bcd is 0 to 2. For example, ten seconds is tens 1, units 0.

Top module parameters: SEC_CYCLES, the clock cycles per second; STEPS_PER_SEC, the LED steps per second; MAX_COUNT, the ceiling in seconds; LED_W, the number of LEDs; SYNC_STAGES, the synchronizer depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_center | input | 1 | Start/pause button, asynchronous level |
| btn_down | input | 1 | Clear button, asynchronous level |
| led | output | LED_W | LED pattern: walking one at the ceiling, zero otherwise |
| tens_bcd | output | 4 | Tens digit of the count, BCD |
| units_bcd | output | 4 | Units digit of the count, BCD |

## Verification
The checker assumes that the count changes in only two ways: by one step up, or by a jump to 00 caused by the clear button or by reset. It also assumes that any LED movement at the ceiling is a rotation by one position. Both assumptions hold only if the buttons change no more often than the synchronizer can follow. The bench therefore holds every button level for several clock cycles, and applies every change on the falling clock edge. It also scales SEC_CYCLES down to 20 and STEPS_PER_SEC to 4. All waits are planned against that timing, so every sample falls at a known prescaler phase.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef logic [3:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } bcd_pair_t;
endpackage

// File: rtl/sw_btn_sync.sv
module sw_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], btn_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.chain[STAGES-1];
    assign rise  = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && !restart && (st_q.cnt == LAST);
        if (restart)   st_d.cnt = '0;
        else if (tick) st_d.cnt = '0;
        else if (en)   st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sw_bcd_count.sv
module sw_bcd_count
    import sw_pkg::*;
#(
    parameter int MAX_COUNT = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      inc,
    output bcd_pair_t value,
    output logic      at_max
);
    localparam bcd_t TOP_TENS  = bcd_t'(MAX_COUNT / 10);
    localparam bcd_t TOP_UNITS = bcd_t'(MAX_COUNT % 10);

    typedef struct packed {
        bcd_pair_t cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign at_max = (st_q.cnt.tens == TOP_TENS) && (st_q.cnt.units == TOP_UNITS);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && !at_max) begin
            if (st_q.cnt.units == bcd_t'(9)) begin
                st_d.cnt.units = '0;
                st_d.cnt.tens  = st_q.cnt.tens + 1'b1;
            end else begin
                st_d.cnt.units = st_q.cnt.units + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;
endmodule

// File: rtl/sw_led_walk.sv
module sw_led_walk #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             step,
    output logic [WIDTH-1:0] led
);
    localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(WIDTH - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
    } walk_st_t;

    walk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active)                 st_d.pos = '0;
        else if (step) begin
            if (st_q.pos == LAST_POS) st_d.pos = '0;
            else                      st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_dec
        assign led[i] = active && (st_q.pos == PW'(i));
    end
endmodule

// File: rtl/sw_stopwatch.sv
module sw_stopwatch
    import sw_pkg::*;
#(
    parameter int SEC_CYCLES    = 100_000_000,
    parameter int STEPS_PER_SEC = 16,
    parameter int MAX_COUNT     = 20,
    parameter int LED_W         = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_center,
    input  logic             btn_down,
    output logic [LED_W-1:0] led,
    output logic [3:0]       tens_bcd,
    output logic [3:0]       units_bcd
);
    localparam int STEP_CYCLES = SEC_CYCLES / STEPS_PER_SEC;

    typedef struct packed {
        logic run;
    } top_st_t;

    top_st_t   st_d, st_q;
    logic      center_lvl, center_rise;
    logic      down_lvl, down_rise;
    logic      sec_tick, step_tick, at_max;
    bcd_pair_t count;

    sw_btn_sync #(.STAGES(SYNC_STAGES)) u_sync_center (
        .clk(clk), .rst_n(rst_n), .btn_in(btn_center),
        .level(center_lvl), .rise(center_rise)
    );

    sw_btn_sync #(.STAGES(SYNC_STAGES)) u_sync_down (
        .clk(clk), .rst_n(rst_n), .btn_in(btn_down),
        .level(down_lvl), .rise(down_rise)
    );

    always_comb begin
        st_d     = st_q;
        st_d.run = st_q.run ^ center_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sw_tick_gen #(.PERIOD(SEC_CYCLES)) u_sec_tick (
        .clk(clk), .rst_n(rst_n), .en(st_q.run),
        .restart(down_lvl), .tick(sec_tick)
    );

    sw_bcd_count #(.MAX_COUNT(MAX_COUNT)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(down_lvl), .inc(sec_tick),
        .value(count), .at_max(at_max)
    );

    sw_tick_gen #(.PERIOD(STEP_CYCLES)) u_step_tick (
        .clk(clk), .rst_n(rst_n), .en(at_max),
        .restart(!at_max), .tick(step_tick)
    );

    sw_led_walk #(.WIDTH(LED_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .active(at_max),
        .step(step_tick), .led(led)
    );

    assign tens_bcd  = count.tens;
    assign units_bcd = count.units;
endmodule

// File: rtl/sw_stopwatch_chk.sv
module sw_stopwatch_chk #(
    parameter int MAX_COUNT = 20,
    parameter int LED_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LED_W-1:0] led,
    input logic [3:0]       tens_bcd,
    input logic [3:0]       units_bcd
);
    logic [7:0]       val;
    logic             at_top;
    logic [7:0]       val_prev_q;
    logic             top_prev_q;
    logic [LED_W-1:0] led_prev_q;

    assign val    = 8'(tens_bcd) * 8'd10 + 8'(units_bcd);
    assign at_top = (val == 8'(MAX_COUNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_prev_q <= '0;
            top_prev_q <= 1'b0;
            led_prev_q <= '0;
        end else begin
            val_prev_q <= val;
            top_prev_q <= at_top;
            led_prev_q <= led;
        end
    end

    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        (units_bcd <= 4'd9) && (tens_bcd <= 4'(MAX_COUNT / 10)));  // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        val <= 8'(MAX_COUNT));  // R3
    AST_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (top_prev_q && val != val_prev_q) |-> (val == 8'd0));  // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (val != val_prev_q) |-> (val == val_prev_q + 8'd1 || val == 8'd0));  // R2
    AST_LED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !at_top |-> (led == '0));  // R7
    AST_LED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |-> ($countones(led) == 1));  // R8
    AST_LED_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && top_prev_q && led != led_prev_q) |->
            (led == {led_prev_q[LED_W-2:0], led_prev_q[LED_W-1]}));  // R8
    AST_LED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && !top_prev_q) |-> (led == LED_W'(1)));  // R8
endmodule

bind sw_stopwatch sw_stopwatch_chk #(.MAX_COUNT(MAX_COUNT), .LED_W(LED_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .led(led),
    .tens_bcd(tens_bcd), .units_bcd(units_bcd)
);

// File: tb/sw_stopwatch_bench.sv
module sw_stopwatch_bench;
    localparam int SEC   = 20;
    localparam int STEPS = 4;
    localparam int LEDS  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            btn_center = 1'b0;
    logic            btn_down = 1'b0;
    logic [LEDS-1:0] led;
    logic [3:0]      tens_bcd, units_bcd;
    int              total = 0;
    int              bad = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    sw_stopwatch #(
        .SEC_CYCLES(SEC), .STEPS_PER_SEC(STEPS), .MAX_COUNT(20),
        .LED_W(LEDS), .SYNC_STAGES(2)
    ) u_sw_stopwatch (
        .clk(clk), .rst_n(rst_n), .btn_center(btn_center), .btn_down(btn_down),
        .led(led), .tens_bcd(tens_bcd), .units_bcd(units_bcd)
    );

    // row: {op[1:0], arg[15:0], req[3:0], tens[3:0], units[3:0]}
    // op 0 = wait arg cycles, 1 = press start/pause, 2 = press clear
    localparam logic [29:0] VECS [0:14] = '{
        {2'd0, 16'd30,  4'd1, 4'd0, 4'd0},
        {2'd1, 16'd0,   4'd4, 4'd0, 4'd0},
        {2'd0, 16'd23,  4'd2, 4'd0, 4'd1},
        {2'd0, 16'd160, 4'd2, 4'd0, 4'd9},
        {2'd0, 16'd25,  4'd9, 4'd1, 4'd0},
        {2'd1, 16'd0,   4'd5, 4'd1, 4'd0},
        {2'd0, 16'd100, 4'd5, 4'd1, 4'd0},
        {2'd1, 16'd0,   4'd5, 4'd1, 4'd1},
        {2'd0, 16'd200, 4'd3, 4'd2, 4'd0},
        {2'd0, 16'd100, 4'd3, 4'd2, 4'd0},
        {2'd2, 16'd0,   4'd6, 4'd0, 4'd0},
        {2'd0, 16'd28,  4'd6, 4'd0, 4'd1},
        {2'd1, 16'd0,   4'd4, 4'd0, 4'd1},
        {2'd2, 16'd0,   4'd6, 4'd0, 4'd0},
        {2'd0, 16'd60,  4'd6, 4'd0, 4'd0}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd9:    return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_count(input string req, input int t, input int u);
        check(tens_bcd == 4'(t) && units_bcd == 4'(u), req, "count",
              int'(tens_bcd) * 10 + int'(units_bcd), t * 10 + u);
    endtask

    task automatic press(input bit which);
        if (which) btn_down = 1'b1; else btn_center = 1'b1;
        repeat (6) @(negedge clk);
        btn_center = 1'b0;
        btn_down   = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check_count("R1", 0, 0);
        check(led == '0, "R1", "led at reset", int'(led), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            logic [29:0] v;
            v = VECS[i];
            case (v[29:28])
                2'd0:    repeat (int'(v[27:12])) @(negedge clk);
                2'd1:    press(1'b0);
                default: press(1'b1);
            endcase
            check_count(req_name(v[11:8]), int'(v[7:4]), int'(v[3:0]));
            if (v[7:4] == 4'd2)  // R8: one LED lit at the ceiling
                check($countones(led) == 1, "R8", "one lit LED", $countones(led), 1);
            else                 // R7: dark below the ceiling
                check(led == '0, "R7", "LEDs dark", int'(led), 0);
        end

        // R4: holding the button toggles once (paused, count 00, phase 0)
        btn_center = 1'b1;
        repeat (60) @(negedge clk);
        check_count("R4", 0, 2);
        btn_center = 1'b0;
        repeat (4) @(negedge clk);
        check_count("R4", 0, 3);

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_count("R1", 0, 0);
        check(led == '0, "R1", "led in reset", int'(led), 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check_count("R1", 0, 0);

        // R8: the walking one at the ceiling
        press(1'b0);
        for (int i = 0; i < 600 && tens_bcd != 4'd2; i++) @(negedge clk);
        check_count("R3", 2, 0);
        check(led == 16'h0001, "R8", "first LED", int'(led), 1);
        repeat (4) @(negedge clk);
        check(led == 16'h0001, "R8", "before step", int'(led), 1);
        repeat (1) @(negedge clk);
        check(led == 16'h0002, "R8", "after step", int'(led), 2);
        repeat (70) @(negedge clk);
        check(led == 16'h8000, "R8", "top LED", int'(led), 32768);
        repeat (5) @(negedge clk);
        check(led == 16'h0001, "R8", "wrap", int'(led), 1);
        check_count("R3", 2, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule